// File: doc/BRIEF.md
# Reference Line Period Meter

This block times an external horizontal sync signal. It counts cycles of the reference clock (nominally 27 MHz) from one active sync edge to the next. The result is published as a 16-bit read-only status value. The sync input passes through a two-flop synchronizer, and the active edge is chosen by a polarity pin. A free-running interval counter is sampled and restarted on every active edge.

The published period is sticky. It changes only when a valid interval differs from the value already held. When that happens, a one-cycle update strobe fires. If sync stops arriving, or an interval runs so long that the counter reaches its ceiling, the published value stays as it is. After such a loss, the next edge only restarts timing, and a new value needs one more full interval. All pins are plain control and status levels. There is no data stream, and so no valid/ready handshake and no back-pressure.

Top module: `line_period_meter`

## Requirements
- R1: While reset is asserted and after its release, `period_o` reads 0 and `period_upd_o` is 0 until the first valid measurement.
- R2: A valid measurement equals the number of `clk` cycles between two successive active edges of `hsync_i`, reported as an unsigned 16-bit count.
- R3: `edge_rise_i` = 1 selects the low-to-high transition of `hsync_i` as the active edge, and 0 selects the high-to-low transition; the other transition has no effect on the measurement.
- R4: The first active edge after reset only starts an interval; it produces no update of `period_o`.
- R5: `period_o` is replaced, and `period_upd_o` pulses high for exactly one cycle, only when a valid measurement differs from the held value; an equal measurement leaves both unchanged.
- R6: When no active edge arrives, `period_o` holds its value indefinitely and `period_upd_o` stays 0.
- R7: An interval whose count reaches 65535 (FFFFh) is treated as reference loss: the edge that ends it is not captured and only restarts timing, so an interval of 65534 cycles is the longest that can be reported.
- R8: A new value appears on `period_o`, together with the strobe, after the third rising `clk` edge following the change of `hsync_i` that starts the active edge: two synchronizer stages, then the capture register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock whose cycles are counted |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_i | input | 1 | Asynchronous horizontal sync from outside the chip |
| edge_rise_i | input | 1 | Active-edge select: 1 = rising, 0 = falling |
| period_o | output | 16 | Last accepted line period in clock cycles |
| period_upd_o | output | 1 | One-cycle strobe when `period_o` takes a new value |

## Verification
A wrong interval counter shows up as a published period that is off by a fixed number of cycles. This is visible three cycles after the second active edge. A lost or stuck arming flag shows up either as an update on the very first edge or as no update ever. A broken saturation path shows up only at the end of a boundary-length interval, as a bogus capture of FFFFh or as a missed 65534. Strobe faults appear as extra pulses when equal periods repeat, or as a pulse one cycle off from the value change.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  parameter int unsigned LPM_PERIOD_W = 16;

  typedef enum logic {
    LPM_EDGE_FALL = 1'b0,
    LPM_EDGE_RISE = 1'b1
  } lpm_edge_e;

endpackage

// File: rtl/lpm_sync_edge.sv
module lpm_sync_edge
  import lpm_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      async_i,
  input  lpm_edge_e sense_i,
  output logic      edge_o
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;
  logic              level;

  // synchronizer chain, stage 0 faces the pin
  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign level = chain_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= level;
  end

  always_comb begin
    unique case (sense_i)
      LPM_EDGE_RISE: edge_o = level & ~last_q;
      default:       edge_o = ~level & last_q;
    endcase
  end

  // R3: a rising-sense edge needs the pin high two samples back
  p_rise_from_pin_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_o && sense_i == LPM_EDGE_RISE && STAGES == 2) |-> $past(async_i, 2));

  // R3: a falling-sense edge needs the pin low two samples back
  p_fall_from_pin_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_o && sense_i == LPM_EDGE_FALL && STAGES == 2) |-> !$past(async_i, 2));

endmodule

// File: rtl/lpm_interval_counter.sv
module lpm_interval_counter
  import lpm_pkg::*;
#(
  parameter int unsigned W = LPM_PERIOD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         edge_i,
  output logic         cap_vld_o,
  output logic [W-1:0] cap_val_o
);

  localparam logic [W-1:0] CEIL = {W{1'b1}};
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] cnt_q;
  logic         armed_q;
  logic         at_ceil;

  assign at_ceil = (cnt_q == CEIL);

  // cnt_q holds cycles elapsed since the last edge (1 in the cycle after it)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (edge_i) begin
      cnt_q <= ONE;
    end else if (!at_ceil) begin
      cnt_q <= cnt_q + ONE;
    end
  end

  // armed after any edge; dropped when the interval reaches the ceiling
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (edge_i) begin
      armed_q <= 1'b1;
    end else if (at_ceil) begin
      armed_q <= 1'b0;
    end
  end

  assign cap_vld_o = edge_i & armed_q & ~at_ceil;
  assign cap_val_o = cnt_q;

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_i && !at_ceil) |=> (cnt_q == $past(cnt_q) + ONE));

  p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    edge_i |=> (cnt_q == ONE && armed_q));

  p_ceiling_disarms_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (at_ceil && !edge_i) |=> (at_ceil && !armed_q));

  p_capture_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_vld_o |-> (cap_val_o != '0 && cap_val_o != CEIL));

  // R4: the edge that arms cannot also capture
  p_first_edge_only_arms_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_i && !armed_q) |-> !cap_vld_o);

endmodule

// File: rtl/lpm_period_hold.sv
module lpm_period_hold
  import lpm_pkg::*;
#(
  parameter int unsigned W = LPM_PERIOD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_vld_i,
  input  logic [W-1:0] cap_val_i,
  output logic [W-1:0] period_o,
  output logic         upd_o
);

  logic [W-1:0] held_q;
  logic         upd_q;
  logic         differs;

  assign differs = (cap_val_i != held_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= cap_vld_i & differs;
      if (cap_vld_i && differs) begin
        held_q <= cap_val_i;
      end
    end
  end

  assign period_o = held_q;
  assign upd_o    = upd_q;

  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_vld_i |=> ($stable(held_q) && !upd_q));

  p_load_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_vld_i |=> (held_q == $past(cap_val_i)));

  p_strobe_on_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |-> (held_q != $past(held_q)));

  p_change_has_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q != $past(held_q)) |-> upd_q);

endmodule

// File: rtl/line_period_meter.sv
module line_period_meter
  import lpm_pkg::*;
#(
  parameter int unsigned PERIOD_W    = LPM_PERIOD_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hsync_i,
  input  logic                edge_rise_i,
  output logic [PERIOD_W-1:0] period_o,
  output logic                period_upd_o
);

  lpm_edge_e             sense;
  logic                  act_edge;
  logic                  cap_vld;
  logic [PERIOD_W-1:0]   cap_val;

  assign sense = edge_rise_i ? LPM_EDGE_RISE : LPM_EDGE_FALL;

  lpm_sync_edge #(
    .STAGES (SYNC_STAGES)
  ) u_sync_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (hsync_i),
    .sense_i (sense),
    .edge_o  (act_edge)
  );

  lpm_interval_counter #(
    .W (PERIOD_W)
  ) u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .edge_i    (act_edge),
    .cap_vld_o (cap_vld),
    .cap_val_o (cap_val)
  );

  lpm_period_hold #(
    .W (PERIOD_W)
  ) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_vld_i (cap_vld),
    .cap_val_i (cap_val),
    .period_o  (period_o),
    .upd_o     (period_upd_o)
  );

  p_reset_clears_r1: assert property (@(posedge clk)
    !rst_n |=> (period_o == '0 && !period_upd_o));

endmodule

// File: tb/line_period_meter_tb.sv
`timescale 1ns/1ps
module line_period_meter_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hsync = 1'b0;
  logic        rise_sel = 1'b1;
  logic [15:0] period;
  logic        upd;

  int n_chk = 0;
  int n_bad = 0;
  int upd_cnt = 0;
  logic act_lvl = 1'b1;

  line_period_meter u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .hsync_i      (hsync),
    .edge_rise_i  (rise_sel),
    .period_o     (period),
    .period_upd_o (upd)
  );

  always #10 clk = ~clk;

  always @(negedge clk) if (rst_n && upd) upd_cnt++;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply_reset(input logic rise);
    rst_n    = 1'b0;
    rise_sel = rise;
    act_lvl  = rise;
    hsync    = ~rise;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    upd_cnt = 0;
  endtask

  // active level for 4 cycles, idle for the rest; returns gap cycles later
  task automatic fire(input int gap);
    hsync = act_lvl;
    repeat (4) @(negedge clk);
    hsync = ~act_lvl;
    repeat (gap - 4) @(negedge clk);
  endtask

  task automatic t_reset_state;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 period in reset", period, 0);
    apply_reset(1'b1);
    check("R1 period after reset", period, 0);
    check("R1 strobe after reset", upd, 0);
  endtask

  task automatic t_measure_and_change;
    fire(120);
    check("R4 first edge no update", period, 0);
    check("R4 first edge no strobe", upd_cnt, 0);
    fire(120);
    check("R2 period 120", period, 120);
    check("R5 one strobe", upd_cnt, 1);
    fire(300);
    check("R5 equal period kept", period, 120);
    check("R5 equal period no strobe", upd_cnt, 1);
    fire(50);
    check("R2 period 300", period, 300);
    check("R5 second strobe", upd_cnt, 2);
  endtask

  task automatic t_latency;
    hsync = act_lvl;
    @(negedge clk);
    @(negedge clk);
    check("R8 old value after two edges", period, 300);
    check("R8 no strobe yet", upd, 0);
    @(negedge clk);
    check("R8 new value after third edge", period, 50);
    check("R8 strobe with value", upd, 1);
    @(negedge clk);
    check("R5 strobe one cycle", upd, 0);
    hsync = ~act_lvl;
    repeat (10) @(negedge clk);
  endtask

  task automatic t_hold;
    int moved = 0;
    int c0 = upd_cnt;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (period !== 16'd50) moved++;
    end
    check("R6 period held without sync", moved, 0);
    check("R6 no strobe without sync", upd_cnt - c0, 0);
  endtask

  task automatic t_falling;
    apply_reset(1'b0);
    fire(80);
    check("R4 falling first edge", period, 0);
    fire(80);
    check("R3 falling edge period 80", period, 80);
    fire(64);
    fire(9);
    check("R3 falling edge period 64", period, 64);
    check("R3 strobe count falling", upd_cnt, 2);
  endtask

  task automatic t_saturation;
    apply_reset(1'b1);
    fire(200);
    fire(65535);
    check("R6 held across long gap", period, 200);
    fire(65534);
    check("R7 ceiling edge not captured", period, 200);
    check("R7 no strobe at ceiling", upd_cnt, 1);
    fire(10);
    check("R7 longest period 65534", period, 65534);
    check("R7 strobe for longest", upd_cnt, 2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_measure_and_change();
    t_latency();
    t_hold();
    t_falling();
    t_saturation();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule